// File: doc/BRIEF.md
# Flash Command Register Front End

This block is a synchronous model of the command decoder that sits between a byte-wide NOR flash array and its host bus. It samples chip enable, output enable and write enable on a system clock and treats each low-to-high transition of write enable, with the chip selected, as one bus write. The address is taken when write enable falls and the command or data byte when it rises. A sequence of these writes moves the block between read, identifier read, erase, erase verify, program, program verify and reset handling.

Erase and program are two-write sequences that emit a one-cycle start strobe to the array model. A running operation ends in one of four ways: its verify command is written, reset is written twice in a row, the program-voltage-valid flag drops, or the internal stop timer expires. Each of these emits a one-cycle stop strobe of the matching kind. Verify modes redirect the array read address to the latched byte address. Identifier mode replaces array data with two fixed codes.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, and in every cycle where vpp_ok_i is low, the mode is read. Writes made while vpp_ok_i is low start nothing. Dropping vpp_ok_i while an operation runs emits its stop strobe.
- R2: A write's address is the addr_i value sampled when we_ni falls with ce_ni low. The byte is the data_i value sampled when we_ni rises with ce_ni low.
- R3: data_oe_o is 1 only when ce_ni and oe_ni are both 0. In read mode, array_addr_o follows addr_i and data_o equals array_rdata_i.
- R4: Writing 80h or 90h selects identifier mode. Reads then return 20h when address bit 0 is 0 and F4h when it is 1.
- R5: Writing 20h and then 20h pulses erase_start_o for one cycle, in the cycle after the second rising edge is sampled. A different second byte starts nothing and returns to read mode.
- R6: Writing A0h latches the write address and pulses erase_stop_o if an erase runs. Later reads return the array byte at the latched address.
- R7: Writing 40h and then one more write pulses prog_start_o. That write's address and byte appear on prog_addr_o and prog_data_o.
- R8: Writing C0h pulses prog_stop_o if a program runs. Later reads return the array byte at the latched program address.
- R9: Two consecutive FFh writes abort a running operation with its stop strobe and select read mode. A single FFh followed by another command does not abort.
- R10: An unverified erase or program is stopped by its own strobe exactly ERS_CYCLES or PGM_CYCLES clocks after its start strobe. A later verify write then emits no strobe.
- R11: A command byte with no defined meaning selects read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| vpp_ok_i | input | 1 | Program voltage valid |
| addr_i | input | AW | Byte address |
| data_i | input | 8 | Write data / command byte |
| array_rdata_i | input | 8 | Array byte at array_addr_o |
| array_addr_o | output | AW | Array read address |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Tristate enable for data_o |
| erase_start_o | output | 1 | Erase start pulse |
| erase_stop_o | output | 1 | Erase stop pulse |
| prog_start_o | output | 1 | Program start pulse |
| prog_stop_o | output | 1 | Program stop pulse |
| prog_addr_o | output | AW | Latched program address |
| prog_data_o | output | 8 | Latched program byte |

## Verification
Every possible first command byte is written once. Each is followed by a read at address 1 and then a 00h write. This separates the identifier codes from array data and the undefined bytes from the defined ones, and confirms that no stray strobe fires. All four combinations of chip enable and output enable are swept over a range of addresses, which separates output gating from the read path. The erase and program sequences are tried in four ways: ended by verify, by double reset, by the stop timer and by loss of program voltage. In each case the number of cycles to the stop strobe is counted. A write whose address changes between the falling and rising edge of write enable shows which of the two addresses is latched.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    M_READ, M_IDENT, M_ERS_ARM, M_PGM_ARM, M_RST_ARM, M_ERS_VFY, M_PGM_VFY
  } mode_e;

  typedef enum logic [1:0] {OP_NONE, OP_ERASE, OP_PROG} op_e;

  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_ID_A   = 8'h80;
  localparam logic [7:0] CMD_ID_B   = 8'h90;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_EVFY   = 8'hA0;
  localparam logic [7:0] CMD_PROG   = 8'h40;
  localparam logic [7:0] CMD_PVFY   = 8'hC0;
  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] ID_MFR     = 8'h20;
  localparam logic [7:0] ID_DEV     = 8'hF4;
endpackage

// File: rtl/fcr_bus_sampler.sv
module fcr_bus_sampler #(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  output logic          wr_evt_o,
  output logic [AW-1:0] wr_addr_o
);
  logic we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q      <= 1'b1;
      wr_addr_o <= '0;
    end else begin
      we_q <= we_ni;
      if (!ce_ni && we_q && !we_ni) wr_addr_o <= addr_i;  // falling edge
    end
  end

  assign wr_evt_o = !ce_ni && !we_q && we_ni;  // rising edge
endmodule

// File: rtl/fcr_cmd_decoder.sv
module fcr_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vpp_ok_i,
  input  logic          wr_evt_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  output mode_e         mode_o,
  output logic [AW-1:0] vfy_addr_o,
  output logic [7:0]    op_data_o,
  output logic          start_ers_o,
  output logic          start_pgm_o,
  output logic          stop_ers_o,
  output logic          stop_pgm_o,
  output logic          abort_o
);
  mode_e         mode_q, mode_d, f_mode;
  logic [AW-1:0] vfy_q, vfy_d;
  logic [7:0]    opd_q, opd_d;
  logic          f_se, f_sp, f_lat;

  // first-cycle decode of a command byte
  always_comb begin
    f_se = 1'b0; f_sp = 1'b0; f_lat = 1'b0;
    unique case (wr_data_i)
      CMD_READ:           f_mode = M_READ;
      CMD_ID_A, CMD_ID_B: f_mode = M_IDENT;
      CMD_ERASE:          f_mode = M_ERS_ARM;
      CMD_PROG:           f_mode = M_PGM_ARM;
      CMD_RESET:          f_mode = M_RST_ARM;
      CMD_EVFY: begin f_mode = M_ERS_VFY; f_se = 1'b1; f_lat = 1'b1; end
      CMD_PVFY: begin f_mode = M_PGM_VFY; f_sp = 1'b1; end
      default:            f_mode = M_READ;
    endcase
  end

  always_comb begin
    mode_d = mode_q; vfy_d = vfy_q; opd_d = opd_q;
    start_ers_o = 1'b0; start_pgm_o = 1'b0;
    stop_ers_o = 1'b0; stop_pgm_o = 1'b0; abort_o = 1'b0;
    if (!vpp_ok_i) begin
      mode_d  = M_READ;
      abort_o = 1'b1;
    end else if (wr_evt_i) begin
      if (mode_q == M_ERS_ARM) begin
        mode_d      = M_READ;
        start_ers_o = (wr_data_i == CMD_ERASE);
      end else if (mode_q == M_PGM_ARM) begin
        mode_d      = M_READ;
        start_pgm_o = 1'b1;
        vfy_d       = wr_addr_i;
        opd_d       = wr_data_i;
      end else if (mode_q == M_RST_ARM && wr_data_i == CMD_RESET) begin
        mode_d  = M_READ;
        abort_o = 1'b1;
      end else begin
        mode_d     = f_mode;
        stop_ers_o = f_se;
        stop_pgm_o = f_sp;
        if (f_lat) vfy_d = wr_addr_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_READ;
      vfy_q  <= '0;
      opd_q  <= '0;
    end else begin
      mode_q <= mode_d;
      vfy_q  <= vfy_d;
      opd_q  <= opd_d;
    end
  end

  assign mode_o     = mode_q;
  assign vfy_addr_o = vfy_q;
  assign op_data_o  = opd_q;

  assert_vpp_low_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_ok_i |=> mode_q == M_READ);
endmodule

// File: rtl/fcr_op_timer.sv
module fcr_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int ERS_CYCLES = 2500000,
  parameter int PGM_CYCLES = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_ers_i,
  input  logic start_pgm_i,
  input  logic stop_ers_i,
  input  logic stop_pgm_i,
  input  logic abort_i,
  output logic erase_start_o,
  output logic erase_stop_o,
  output logic prog_start_o,
  output logic prog_stop_o
);
  localparam int MAXL = (ERS_CYCLES > PGM_CYCLES) ? ERS_CYCLES : PGM_CYCLES;
  localparam int CW   = $clog2(MAXL + 1);

  op_e           op_q;
  logic [CW-1:0] cnt_q;
  logic          expire, end_ers, end_pgm, start_any;

  assign expire    = (op_q != OP_NONE) && (cnt_q == CW'(1));
  assign start_any = start_ers_i || start_pgm_i;
  assign end_ers   = (op_q == OP_ERASE) && (stop_ers_i || abort_i || expire || start_any);
  assign end_pgm   = (op_q == OP_PROG)  && (stop_pgm_i || abort_i || expire || start_any);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_NONE;
      cnt_q <= '0;
      erase_start_o <= 1'b0; erase_stop_o <= 1'b0;
      prog_start_o  <= 1'b0; prog_stop_o  <= 1'b0;
    end else begin
      erase_start_o <= start_ers_i;
      prog_start_o  <= start_pgm_i;
      erase_stop_o  <= end_ers;
      prog_stop_o   <= end_pgm;
      if (start_ers_i) begin
        op_q <= OP_ERASE; cnt_q <= CW'(ERS_CYCLES);
      end else if (start_pgm_i) begin
        op_q <= OP_PROG;  cnt_q <= CW'(PGM_CYCLES);
      end else if (end_ers || end_pgm) begin
        op_q <= OP_NONE;  cnt_q <= '0;
      end else if (op_q != OP_NONE) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assert_ers_stop_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_stop_o |-> $past(op_q == OP_ERASE));
  assert_pgm_stop_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stop_o |-> $past(op_q == OP_PROG));
  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAXL));
  assert_one_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_start_o && prog_start_o));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int AW         = 18,
  parameter int ERS_CYCLES = 2500000,
  parameter int PGM_CYCLES = 2500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic          vpp_ok_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic [7:0]    array_rdata_i,
  output logic [AW-1:0] array_addr_o,
  output logic [7:0]    data_o,
  output logic          data_oe_o,
  output logic          erase_start_o,
  output logic          erase_stop_o,
  output logic          prog_start_o,
  output logic          prog_stop_o,
  output logic [AW-1:0] prog_addr_o,
  output logic [7:0]    prog_data_o
);
  logic          wr_evt;
  logic [AW-1:0] wr_addr, vfy_addr;
  mode_e         mode;
  logic          s_ers, s_pgm, p_ers, p_pgm, abort;

  fcr_bus_sampler #(.AW(AW)) u_smp (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .addr_i,
    .wr_evt_o(wr_evt), .wr_addr_o(wr_addr)
  );

  fcr_cmd_decoder #(.AW(AW)) u_dec (
    .clk_i, .rst_ni, .vpp_ok_i,
    .wr_evt_i(wr_evt), .wr_addr_i(wr_addr), .wr_data_i(data_i),
    .mode_o(mode), .vfy_addr_o(vfy_addr), .op_data_o(prog_data_o),
    .start_ers_o(s_ers), .start_pgm_o(s_pgm),
    .stop_ers_o(p_ers), .stop_pgm_o(p_pgm), .abort_o(abort)
  );

  fcr_op_timer #(.ERS_CYCLES(ERS_CYCLES), .PGM_CYCLES(PGM_CYCLES)) u_tmr (
    .clk_i, .rst_ni,
    .start_ers_i(s_ers), .start_pgm_i(s_pgm),
    .stop_ers_i(p_ers), .stop_pgm_i(p_pgm), .abort_i(abort),
    .erase_start_o, .erase_stop_o, .prog_start_o, .prog_stop_o
  );

  assign prog_addr_o  = vfy_addr;
  assign array_addr_o = (mode == M_ERS_VFY || mode == M_PGM_VFY) ? vfy_addr : addr_i;
  assign data_oe_o    = !ce_ni && !oe_ni;

  always_comb begin
    if (mode == M_IDENT) data_o = addr_i[0] ? ID_DEV : ID_MFR;
    else                 data_o = array_rdata_i;
  end

  assert_no_start_lowvpp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!vpp_ok_i) |-> !erase_start_o && !prog_start_o);
endmodule

// File: tb/sim_flash_cmd_if.sv
`timescale 1ns/1ps
module sim_flash_cmd_if;
  localparam int AW = 18;
  localparam int ERS = 40;
  localparam int PGM = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, vpp = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] arr_q;
  logic [AW-1:0] arr_a, paddr;
  logic [7:0] dout, pdata;
  logic doe, es, ep, ps, pp;

  int checks = 0, fails = 0, cyc = 0;
  logic w_es, w_ep, w_ps, w_pp;

  always #2 clk = ~clk;

  function automatic logic [7:0] arr(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:16], 6'b0} ^ 8'h5A;
  endfunction
  assign arr_q = arr(arr_a);

  flash_cmd_if #(.AW(AW), .ERS_CYCLES(ERS), .PGM_CYCLES(PGM)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .vpp_ok_i(vpp), .addr_i(addr), .data_i(din), .array_rdata_i(arr_q),
    .array_addr_o(arr_a), .data_o(dout), .data_oe_o(doe),
    .erase_start_o(es), .erase_stop_o(ep), .prog_start_o(ps), .prog_stop_o(pp),
    .prog_addr_o(paddr), .prog_data_o(pdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // write: address taken at fall (af), may change to ar before rise
  task automatic wr2(input logic [AW-1:0] af, input logic [AW-1:0] ar, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = af; we_n = 1'b0;
    @(negedge clk); addr = ar; din = d; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    w_es = es; w_ep = ep; w_ps = ps; w_pp = pp;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr2(a, a, d);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1;
    chk(req, dout, exp);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic no_strobes(input string req);
    chk(req, {w_es, w_ep, w_ps, w_pp}, 4'b0000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset strobes", {es, ep, ps, pp}, 4'b0000);
    chk("R3 reset oe", doe, 1'b0);
    rst_n = 1'b1;
    rd(18'h00123, arr(18'h00123), "R1 reset read mode");

    // R11 / R4: sweep of every first command byte except program arm
    for (int b = 0; b < 256; b++) begin
      if (b == 8'h40) continue;
      wr(18'd1, b[7:0]);
      no_strobes("R11 sweep strobes");
      rd(18'd1, (b == 8'h80 || b == 8'h90) ? 8'hF4 : arr(18'd1), "R11 R4 sweep read");
      wr(18'd0, 8'h00);
    end

    // R3 output gating over ce/oe combos and addresses
    for (int a = 0; a < 64; a++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); ce_n = c[0]; oe_n = c[1]; addr = AW'(a * 4099);
        #1;
        chk("R3 oe gate", doe, (c == 0));
        chk("R3 read data", dout, arr(AW'(a * 4099)));
      end
    end
    ce_n = 1'b1; oe_n = 1'b1;

    // R4 identifier with other high address bits
    wr(0, 8'h90);
    rd(18'h00100, 8'h20, "R4 mfr code");
    rd(18'h00003, 8'hF4, "R4 dev code");
    wr(0, 8'h00);

    // R5 / R6 erase then verify stop
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R5 erase start", w_es, 1'b1);
    wr(18'h2A5C3, 8'hA0);
    chk("R6 erase stop", w_ep, 1'b1);
    rd(18'h00777, arr(18'h2A5C3), "R6 verify read");
    // R5 aborted arm
    wr(0, 8'h20); wr(0, 8'h55);
    chk("R5 abort no start", w_es, 1'b0);
    rd(18'd1, arr(18'd1), "R5 abort read mode");

    // R2 address from falling edge
    wr2(18'h01234, 18'h3FFFF, 8'hA0);
    chk("R2 no stop when idle", w_ep, 1'b0);
    rd(18'h00005, arr(18'h01234), "R2 fall address");

    // R7 / R8 program then verify
    wr(0, 8'h40);
    wr(18'h15A5A, 8'h3C);
    chk("R7 prog start", w_ps, 1'b1);
    chk("R7 prog addr", paddr, 18'h15A5A);
    chk("R7 prog data", pdata, 8'h3C);
    wr(18'h00009, 8'hC0);
    chk("R8 prog stop", w_pp, 1'b1);
    rd(18'h00011, arr(18'h15A5A), "R8 verify read");

    // R9 double reset aborts erase
    wr(0, 8'h20); wr(0, 8'h20);
    wr(0, 8'hFF);
    chk("R9 single FF no stop", w_ep, 1'b0);
    wr(0, 8'hFF);
    chk("R9 double FF stop", w_ep, 1'b1);
    rd(18'd1, arr(18'd1), "R9 read mode");
    // R9 broken reset sequence
    wr(0, 8'h40); wr(18'h00042, 8'h11);
    wr(0, 8'hFF); wr(0, 8'h00);
    chk("R9 broken seq no stop", w_pp, 1'b0);
    wr(0, 8'hFF); wr(0, 8'hFF);
    chk("R9 abort program", w_pp, 1'b1);

    // R10 erase stop timer
    wr(0, 8'h20); wr(0, 8'h20);
    n = 0;
    for (int k = 1; k <= ERS + 5; k++) begin
      @(negedge clk);
      if (ep) begin n = k; break; end
    end
    chk("R10 erase timeout cycles", n, ERS);
    wr(0, 8'hA0);
    chk("R10 late verify no strobe", w_ep, 1'b0);
    // R10 program stop timer
    wr(0, 8'h40); wr(18'h00077, 8'h99);
    n = 0;
    for (int k = 1; k <= PGM + 5; k++) begin
      @(negedge clk);
      if (pp) begin n = k; break; end
    end
    chk("R10 prog timeout cycles", n, PGM);
    wr(0, 8'hC0);
    chk("R10 late pverify no strobe", w_pp, 1'b0);
    wr(0, 8'h00);

    // R1 vpp low: writes ignored
    vpp = 1'b0;
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R1 no erase at low vpp", w_es, 1'b0);
    wr(0, 8'h90);
    rd(18'd0, arr(18'd0), "R1 id ignored at low vpp");
    vpp = 1'b1;
    // R1 vpp drop aborts erase
    wr(0, 8'h20); wr(0, 8'h20);
    @(negedge clk); vpp = 1'b0;
    @(negedge clk);
    chk("R1 vpp drop stop", ep, 1'b1);
    vpp = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule